// File: doc/BRIEF.md
# Admin command queue engine

The engine is the device side of an administrative command channel. The host keeps the command queue in one page of its own memory. That page is an array of fixed-size command slots. The host tells the engine where the page is by writing a page-frame number into a small register file. To hand over work, the host fills the next slots and writes a doorbell with its running total of submitted commands. The engine fetches each pending slot in order through a simple single-word memory port. It decodes the opcode and writes a fixed completion status back into the slot. Only then does it raise its executed-command counter, which the host polls until it matches the doorbell.

Submission and completion are both free-running counts, so the slot is always the executed count modulo the number of slots in a page. Writing zero as the page-frame number acts as a full reset of the engine. It forgets the queue, both counts and any command in flight. Every value on the register port and in command memory is big-endian.

Top module: `admin_cmdq_engine`

## Requirements
- R1: After reset the page-frame, doorbell and executed-count registers read as zero and no memory request is raised.
- R2: Register values are big-endian on the port. The most significant byte travels in reg_wdata[7:0] and reg_rdata[7:0], so a doorbell written as 32'h0100_0000 means one command. Register select: 0 page-frame number, 1 doorbell, 2 executed count (read-only).
- R3: The doorbell holds a cumulative submission total. The engine executes commands until the executed count equals it, and the count reads back through register 2.
- R4: Command n lives at byte address pfn*4096 + (n mod 64)*64. The opcode word is at slot offset 0 and the status word at slot offset 4. The slot index wraps from 63 back to 0.
- R5: Commands run one at a time, in order. Each is one read of its opcode followed by one write of its status. The executed count rises by exactly one, and only in the cycle the status write is accepted. A request holds its address until accepted.
- R6: Opcodes 1, 2 and 3, each read as a big-endian 32-bit word, complete with status 32'h0000_0001, stored big-endian.
- R7: Any other opcode completes with status 32'hFFFF_FFF7 and still advances the executed count.
- R8: A doorbell equal to or behind the executed count (difference zero or negative as a 32-bit signed value) starts no memory traffic.
- R9: A doorbell write while the page-frame number is zero is ignored: the doorbell reads back zero and no traffic starts.
- R10: Writing zero to the page-frame register clears the doorbell and executed count and abandons any command in flight. No memory request follows until a new page is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data, big-endian |
| reg_rdata | output | 32 | Register read data, big-endian, combinational from reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a status write, 0 for an opcode read |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Status word to write, big-endian |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Opcode word read, big-endian |

## Verification
With a memory that acknowledges one cycle after it sees a request, each command takes exactly five cycles. The first starts on the edge after the doorbell write, so the count reaches N five times N edges after that write. The bench samples one edge early to see N-1 and then on the due edge to see N. This proves the count steps neither early nor late. Register effects of a write, such as a doorbell being ignored or a reset by zero page number, are visible from the next falling edge, and the bench reads them there. A monitor checks every accepted memory access against the expected slot address in order as it happens. Idle windows are checked by counting request cycles.

// File: rtl/admin_cmdq_engine.sv
module admin_cmdq_engine #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SLOT_SHIFT = 6,
  parameter int STATUS_OFS = 4,
  parameter logic [31:0] ST_OK  = 32'h0000_0001,
  parameter logic [31:0] ST_BAD = 32'hFFFF_FFF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int SLOT_BITS = PAGE_SHIFT - SLOT_SHIFT;
  localparam int PFN_W     = ADDR_W - PAGE_SHIFT;

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t            state;
  logic [PFN_W-1:0]  pfn_q;
  logic [31:0]       bell_q, done_q, status_q;
  logic [31:0]       wval, lag, op, rsel;
  logic              pfn_we, bell_we, kill, pending, known;
  logic [ADDR_W-1:0] slot_base;

  assign wval    = bswap(reg_wdata);
  assign pfn_we  = reg_wr && reg_addr == 2'd0;
  assign bell_we = reg_wr && reg_addr == 2'd1;
  assign kill    = pfn_we && wval == 32'd0;
  assign lag     = bell_q - done_q;
  assign pending = pfn_q != '0 && lag != 32'd0 && !lag[31];
  assign op      = bswap(mem_rdata);
  assign known   = op == 32'd1 || op == 32'd2 || op == 32'd3;

  assign slot_base = (ADDR_W'(pfn_q) << PAGE_SHIFT)
                   | (ADDR_W'(done_q[SLOT_BITS-1:0]) << SLOT_SHIFT);
  assign mem_req   = state != S_IDLE;
  assign mem_we    = state == S_WRITE;
  assign mem_addr  = slot_base + (mem_we ? ADDR_W'(STATUS_OFS) : '0);
  assign mem_wdata = bswap(status_q);

  always_comb begin
    case (reg_addr)
      2'd0:    rsel = 32'(pfn_q);
      2'd1:    rsel = bell_q;
      2'd2:    rsel = done_q;
      default: rsel = 32'd0;
    endcase
  end
  assign reg_rdata = bswap(rsel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pfn_q    <= '0;
      bell_q   <= '0;
      done_q   <= '0;
      status_q <= '0;
    end else if (kill) begin
      state  <= S_IDLE;
      pfn_q  <= '0;
      bell_q <= '0;
      done_q <= '0;
    end else begin
      if (pfn_we) pfn_q <= wval[PFN_W-1:0];
      if (bell_we && pfn_q != '0) bell_q <= wval;
      case (state)
        S_IDLE:  if (pending) state <= S_READ;
        S_READ:  if (mem_ack) begin
                   status_q <= known ? ST_OK : ST_BAD;
                   state    <= S_WRITE;
                 end
        S_WRITE: if (mem_ack) begin
                   done_q <= done_q + 32'd1;
                   state  <= S_IDLE;
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_r10_quiet_without_page: assert property (@(posedge clk) disable iff (!rst_n)
    pfn_q == '0 |-> !mem_req);

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !pfn_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_count_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != $past(done_q) && !$past(kill)) |-> $past(mem_req && mem_we && mem_ack));

  a_r5_count_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != $past(done_q) && !$past(kill)) |-> done_q == $past(done_q) + 32'd1);

  a_r6_r7_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == bswap(ST_OK) || mem_wdata == bswap(ST_BAD)));

  a_r8_no_work_when_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && bell_q == done_q && !reg_wr) |=> !mem_req);
endmodule

// File: tb/admin_cmdq_engine_bench.sv
module admin_cmdq_engine_bench;
  localparam int PERIOD = 10;
  localparam int PFN    = 5;
  localparam logic [31:0] BASE = 32'(PFN) << 12;
  localparam logic [31:0] OK   = 32'h0000_0001;
  localparam logic [31:0] BAD  = 32'hFFFF_FFF7;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic poke_en = 0;
  logic [9:0] poke_idx = 0;
  logic [31:0] poke_val = 0;
  logic [31:0] mem [1024];
  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0, req_cycles = 0, exp_n = 0;

  always #(PERIOD/2) clk = ~clk;

  admin_cmdq_engine u_admin_cmdq_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  always @(posedge clk) begin
    if (poke_en) mem[poke_idx] <= poke_val;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && mem_req) req_cycles <= req_cycles + 1;
    if (reg_wr && reg_addr == 2'd0) exp_n <= 0;
    else if (rst_n && mem_req && mem_ack) begin
      mon_checks <= mon_checks + 1;
      if (mem_addr != BASE + 32'((exp_n % 64) * 64) + (mem_we ? 32'd4 : 32'd0)) begin
        mon_fails <= mon_fails + 1;
        $display("FAIL R4/R5 access order: addr=%h we=%0d expected slot %0d", mem_addr, mem_we, exp_n % 64);
      end
      if (mem_we) exp_n <= exp_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = bsw(v);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = bsw(reg_rdata);
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    @(negedge clk);
    poke_en = 1; poke_idx = 10'(idx); poke_val = v;
    @(negedge clk);
    poke_en = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 3; a++) begin
      reg_read(2'(a), v);
      check("R1 register zero after reset", v, 32'd0);
    end
    check("R1 no request after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_endian;
    logic [31:0] raw;
    reg_write(2'd0, PFN);
    reg_addr = 2'd0; #1; raw = reg_rdata;
    check("R2 page number read back big-endian", raw, 32'h0500_0000);
    reg_write(2'd1, 32'd1);
    wait_cyc(5);
    reg_addr = 2'd2; #1; raw = reg_rdata;
    check("R2 executed count on port big-endian", raw, 32'h0100_0000);
    check("R6 opcode 1 status", mem[1], bsw(OK));
  endtask

  task automatic t_run_two;
    logic [31:0] v;
    reg_write(2'd1, 32'd3);
    wait_cyc(9);
    reg_read(2'd2, v);
    check("R5 count not early", v, 32'd2);
    wait_cyc(1);
    reg_read(2'd2, v);
    check("R3 count reaches doorbell total", v, 32'd3);
    check("R6 opcode 3 status", mem[17], bsw(OK));
    check("R7 unknown opcode status", mem[33], bsw(BAD));
    check("R4 next slot untouched", mem[49], FILL);
  endtask

  task automatic t_not_ahead;
    logic [31:0] v;
    int r0;
    r0 = req_cycles;
    reg_write(2'd1, 32'd3);
    wait_cyc(15);
    reg_write(2'd1, 32'd1);
    wait_cyc(15);
    check("R8 no traffic for level or lagging doorbell", 32'(req_cycles - r0), 32'd0);
    reg_read(2'd2, v);
    check("R8 count unchanged", v, 32'd3);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    poke(1, FILL);
    poke(17, FILL);
    reg_write(2'd1, 32'd66);
    wait_cyc(5 * 63 - 1);
    reg_read(2'd2, v);
    check("R5 count one short before last status", v, 32'd65);
    wait_cyc(1);
    reg_read(2'd2, v);
    check("R3 count after wrap", v, 32'd66);
    check("R4 last slot status", mem[63 * 16 + 1], bsw(OK));
    check("R4 slot 0 rewritten after wrap", mem[1], bsw(OK));
    check("R4 slot 1 rewritten after wrap", mem[17], bsw(OK));
  endtask

  task automatic t_kill;
    logic [31:0] v;
    int r0;
    reg_write(2'd1, 32'd70);
    wait_cyc(7);
    check("R10 command in flight before reset", {31'd0, mem_req}, 32'd1);
    reg_write(2'd0, 32'd0);
    reg_read(2'd2, v);
    check("R10 count cleared", v, 32'd0);
    reg_read(2'd1, v);
    check("R10 doorbell cleared", v, 32'd0);
    r0 = req_cycles;
    wait_cyc(12);
    check("R10 no traffic after reset", 32'(req_cycles - r0), 32'd0);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    int r0;
    r0 = req_cycles;
    reg_write(2'd1, 32'd2);
    reg_read(2'd1, v);
    check("R9 doorbell ignored without page", v, 32'd0);
    wait_cyc(12);
    check("R9 no traffic without page", 32'(req_cycles - r0), 32'd0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    poke(1, FILL);
    reg_write(2'd0, PFN);
    reg_write(2'd1, 32'd1);
    wait_cyc(5);
    reg_read(2'd2, v);
    check("R10 restart from slot 0 count", v, 32'd1);
    check("R10 restart slot 0 status", mem[1], bsw(OK));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = FILL;
    for (int s = 0; s < 64; s++) begin
      mem[s * 16] = bsw(s == 0 ? 32'd1 : s == 1 ? 32'd3 : s == 2 ? 32'h77 : 32'd2);
    end
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    t_reset;
    t_endian;
    t_run_two;
    t_not_ahead;
    t_wrap;
    t_kill;
    t_ignored;
    t_restart;
    wait_cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule